// File: doc/BRIEF.md
# Paired Register Bank for a 16-bit I/O Expander

This block holds the register file and byte-level command logic behind a 16-bit I/O expander reached over a two-wire serial bus. An upstream bus slave takes care of bit timing, acknowledges and address matching. It hands this block a set of strobes:

- a start pulse and a stop pulse;
- an address-hit pulse, together with the direction bit;
- each received byte, with a valid strobe;
- a request strobe whenever it needs the next byte to return.

The block keeps eight byte-wide registers, arranged as four pairs: input capture, output latch, polarity inversion and direction. Each pair has one register for pin group 0 and one for pin group 1.

In a write, the first byte after the address is a command that selects a register. Every byte after that goes to the register the pointer selects, and the pointer then flips to the other register of the same pair. A long burst therefore keeps alternating between the two registers of one pair. Reads walk the pointer in the same way. A read of an input register samples the pins and applies the polarity mask.

Two port groups drive the pins, with a direction bit for each pin. An active-low interrupt tells the host that an input pin has moved away from the value it last read.

Top module: `ioexp_regbank`

## Requirements
- R1: After reset:
  - both output registers are 8'hFF and both direction registers are 8'hFF;
  - both polarity registers are 8'h00;
  - pin_oe is all zeros and pin_out is all ones;
  - int_n is 1 and rd_byte is 8'h00.
- R2: In a write transaction (address-hit with addr_rw = 0), the first received byte is a command that selects a register. Codes 0..7 map to in0, in1, out0, out1, pol0, pol1, cfg0, cfg1, and pin group p is bits [8p+7:8p]. Each later byte is stored in the selected register.
- R3: After each data byte written or read, the pointer moves to the other register of the same pair (it toggles bit 0 of the code). This continues for any number of bytes, and the pointer is kept between transactions.
- R4: A command byte above 7 is ignored and leaves the pointer unchanged. The data bytes that follow go to the pointer held from before.
- R5: Data written to code 0 or 1 (input registers) is discarded, but the pointer still alternates.
- R6: pin_oe bit i is the inverse of the matching direction bit (1 = input). pin_out carries the output registers.
- R7: A read of an input register returns the pin values XORed with that group's polarity register. rd_byte is valid from the cycle after rd_req.
- R8: A read of an output, polarity or direction register returns the stored value.
- R9: int_n goes low when a pin whose direction bit is 1 differs from the value captured at the last read of its input register. Pins in output mode never cause an interrupt.
- R10: int_n returns high when the group's input register is read, or when the pin returns to its captured value.
- R11: The following have no effect:
  - a received byte outside a write transaction, for example after a stop;
  - rd_req during a write transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated-start pulse |
| bus_stop | input | 1 | Stop pulse |
| addr_hit | input | 1 | Own address matched |
| addr_rw | input | 1 | Direction bit of the address byte, 1 = read |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| rd_req | input | 1 | Slave requests the next read byte |
| rd_byte | output | 8 | Byte returned for the last request |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Per-pin output enable |
| int_n | output | 1 | Active-low input-change interrupt |

## Verification
The hardest state to reach is an interrupt that fires and then clears. For this, the direction register must make some pins inputs, and the captured value must be made to differ from the pin through a read. Then a pin has to be moved that is an input while a neighbouring pin in the same group is an output.

The bench first loads mixed direction and polarity masks. It then reads both input registers to arm the capture. After that it toggles an output-mode pin, which must stay silent, and then an input-mode pin, which it clears once by restoring the pin and once by a read. Pointer retention is exposed with an out-of-range command and with a read strobe placed inside a write.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2,
        PH_READ = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        GRP_IN  = 2'd0,
        GRP_OUT = 2'd1,
        GRP_POL = 2'd2,
        GRP_CFG = 2'd3
    } grp_t;

    localparam logic [BYTE_W-1:0] OUT_RST = '1;
    localparam logic [BYTE_W-1:0] POL_RST = '0;
    localparam logic [BYTE_W-1:0] CFG_RST = '1;
endpackage

// File: rtl/ioexp_ctrl.sv
module ioexp_ctrl
    import ioexp_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic          addr_hit,
    input  logic          addr_rw,
    input  logic [BW-1:0] rx_byte,
    input  logic          rx_valid,
    input  logic          rd_req,
    output logic          wr_en,
    output logic          rd_en,
    output logic [2:0]    ptr
);
    typedef struct packed {
        phase_t     phase;
        logic [2:0] ptr;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  bus_evt;
    logic  cmd_ok;

    assign bus_evt = bus_start | bus_stop | addr_hit;
    assign cmd_ok  = (rx_byte[BW-1:3] == '0);

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        rd_en = 1'b0;
        if (bus_start || bus_stop) begin
            st_d.phase = PH_IDLE;
        end else if (addr_hit) begin
            st_d.phase = addr_rw ? PH_READ : PH_CMD;
        end else begin
            case (st_q.phase)
                PH_CMD: if (rx_valid) begin
                    if (cmd_ok) st_d.ptr = rx_byte[2:0];
                    st_d.phase = PH_DATA;
                end
                PH_DATA: if (rx_valid) begin
                    wr_en      = 1'b1;
                    st_d.ptr   = {st_q.ptr[2:1], ~st_q.ptr[0]};
                end
                PH_READ: if (rd_req) begin
                    rd_en      = 1'b1;
                    st_d.ptr   = {st_q.ptr[2:1], ~st_q.ptr[0]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, ptr: 3'd0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

    AST_PAIR_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA && rx_valid && !bus_evt)
        |=> (ptr[2:1] == $past(ptr[2:1]) && ptr[0] != $past(ptr[0]))); // R3

    AST_CMD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CMD && rx_valid && !cmd_ok && !bus_evt)
        |=> $stable(ptr)); // R4
endmodule

// File: rtl/ioexp_port.sv
module ioexp_port
    import ioexp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic         wr_en,
    input  grp_t         wr_grp,
    input  logic [W-1:0] wdata,
    input  logic         rd_cap,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] cfg_q,
    output logic [W-1:0] rd_in,
    output logic         chg
);
    typedef struct packed {
        logic [W-1:0] outr;
        logic [W-1:0] pol;
        logic [W-1:0] cfg;
        logic [W-1:0] last;
        logic [W-1:0] pin_s;
    } port_s;

    port_s pr_d, pr_q;

    always_comb begin
        pr_d       = pr_q;
        pr_d.pin_s = pin_in;
        if (wr_en) begin
            case (wr_grp)
                GRP_OUT: pr_d.outr = wdata;
                GRP_POL: pr_d.pol  = wdata;
                GRP_CFG: pr_d.cfg  = wdata;
                default: ;
            endcase
        end
        if (rd_cap) pr_d.last = pr_q.pin_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q.outr  <= OUT_RST;
            pr_q.pol   <= POL_RST;
            pr_q.cfg   <= CFG_RST;
            pr_q.last  <= '0;
            pr_q.pin_s <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign out_q = pr_q.outr;
    assign pol_q = pr_q.pol;
    assign cfg_q = pr_q.cfg;
    assign rd_in = pr_q.pin_s ^ pr_q.pol;
    assign chg   = |((pr_q.pin_s ^ pr_q.last) & pr_q.cfg);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_grp == GRP_OUT) |=> $stable(out_q)); // R5

    AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_cap) && pr_q.pin_s == $past(pr_q.pin_s)) |-> !chg); // R10
endmodule

// File: rtl/ioexp_regbank.sv
module ioexp_regbank
    import ioexp_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_start,
    input  logic                       bus_stop,
    input  logic                       addr_hit,
    input  logic                       addr_rw,
    input  logic [PORT_W-1:0]          rx_byte,
    input  logic                       rx_valid,
    input  logic                       rd_req,
    output logic [PORT_W-1:0]          rd_byte,
    input  logic [2*PORT_W-1:0]        pin_in,
    output logic [2*PORT_W-1:0]        pin_out,
    output logic [2*PORT_W-1:0]        pin_oe,
    output logic                       int_n
);
    localparam int NPORT = 2;

    typedef struct packed {
        logic [PORT_W-1:0] rd_byte;
        logic              int_n;
    } top_s;

    top_s tp_d, tp_q;

    logic                          wr_en, rd_en;
    logic [2:0]                    ptr;
    grp_t                          grp;
    logic [NPORT-1:0][PORT_W-1:0]  out_a, pol_a, cfg_a, rdin_a;
    logic [NPORT-1:0]              chg_a;

    assign grp = grp_t'(ptr[2:1]);

    ioexp_ctrl #(.BW(PORT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .addr_hit  (addr_hit),
        .addr_rw   (addr_rw),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .rd_req    (rd_req),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .ptr       (ptr)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ioexp_port #(.W(PORT_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pin_in[p*PORT_W +: PORT_W]),
            .wr_en  (wr_en && (ptr[0] == p[0])),
            .wr_grp (grp),
            .wdata  (rx_byte),
            .rd_cap (rd_en && grp == GRP_IN && (ptr[0] == p[0])),
            .out_q  (out_a[p]),
            .pol_q  (pol_a[p]),
            .cfg_q  (cfg_a[p]),
            .rd_in  (rdin_a[p]),
            .chg    (chg_a[p])
        );
        assign pin_out[p*PORT_W +: PORT_W] = out_a[p];
        assign pin_oe[p*PORT_W +: PORT_W]  = ~cfg_a[p];
    end

    always_comb begin
        tp_d       = tp_q;
        tp_d.int_n = ~(|chg_a);
        if (rd_en) begin
            case (grp)
                GRP_IN:  tp_d.rd_byte = rdin_a[ptr[0]];
                GRP_OUT: tp_d.rd_byte = out_a[ptr[0]];
                GRP_POL: tp_d.rd_byte = pol_a[ptr[0]];
                default: tp_d.rd_byte = cfg_a[ptr[0]];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '{rd_byte: '0, int_n: 1'b1};
        end else begin
            tp_q <= tp_d;
        end
    end

    assign rd_byte = tp_q.rd_byte;
    assign int_n   = tp_q.int_n;

    AST_INT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> $past(|chg_a)); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_byte)); // R11
endmodule

// File: tb/sim_ioexp_regbank.sv
module sim_ioexp_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, addr_hit = 1'b0, addr_rw = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0, rd_req = 1'b0;
    logic [7:0]  rd_byte;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out, pin_oe;
    logic        int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ioexp_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_hit(addr_hit), .addr_rw(addr_rw), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rd_req(rd_req), .rd_byte(rd_byte), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .int_n(int_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_addr(input logic rw);
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0; addr_hit = 1'b1; addr_rw = rw;
        @(negedge clk) addr_hit = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic send_stop();
        bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        b = rd_byte;
    endtask

    task automatic set_ptr(input logic [7:0] cmd);
        send_addr(1'b0);
        send_byte(cmd);
        send_stop();
    endtask

    task automatic t_reset();
        check("R1 pin_out", pin_out, 16'hFFFF);
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 int_n", int_n, 1'b1);
        check("R1 rd_byte", rd_byte, 8'h00);
    endtask

    task automatic t_write_pairs();
        send_addr(1'b0);
        send_byte(8'd3);
        send_byte(8'hA1);
        send_byte(8'hB2);
        send_byte(8'hC3);
        send_stop();
        check("R2 R3 out burst alternates", pin_out, 16'hC3B2);
        send_addr(1'b0);
        send_byte(8'd6);
        send_byte(8'h0F);
        send_byte(8'hF0);
        send_stop();
        check("R6 pin_oe from cfg", pin_oe, 16'h0FF0);
        check("R6 pin_out kept", pin_out, 16'hC3B2);
    endtask

    task automatic t_read_pairs();
        logic [7:0] b;
        set_ptr(8'd7);
        send_addr(1'b1);
        read_byte(b); check("R8 read cfg1", b, 8'hF0);
        read_byte(b); check("R3 read alternates to cfg0", b, 8'h0F);
        read_byte(b); check("R3 read back to cfg1", b, 8'hF0);
        send_stop();
    endtask

    task automatic t_bad_cmd();
        send_addr(1'b0);
        send_byte(8'd2);
        send_byte(8'h11);
        send_stop();
        send_addr(1'b0);
        send_byte(8'd9);
        send_byte(8'h22);
        send_stop();
        check("R4 bad command keeps pointer", pin_out, 16'h2211);
    endtask

    task automatic t_input_discard();
        logic [7:0] b;
        send_addr(1'b0);
        send_byte(8'd0);
        send_byte(8'h55);
        send_byte(8'h66);
        send_byte(8'h77);
        send_stop();
        check("R5 input write leaves outputs", pin_out, 16'h2211);
        send_addr(1'b1);
        read_byte(b); check("R5 in1 not written (ptr alternated to 1)", b, 8'h00);
        read_byte(b); check("R5 in0 not written", b, 8'h00);
        send_stop();
    endtask

    task automatic t_polarity();
        logic [7:0] b;
        send_addr(1'b0);
        send_byte(8'd4);
        send_byte(8'hFF);
        send_byte(8'h0F);
        send_stop();
        pin_in = 16'h3C5A;
        wait_n(3);
        check("R9 input change raises int", int_n, 1'b0);
        set_ptr(8'd0);
        send_addr(1'b1);
        read_byte(b); check("R7 in0 xor pol0", b, 8'hA5);
        read_byte(b); check("R7 in1 xor pol1", b, 8'h33);
        send_stop();
        wait_n(2);
        check("R10 read clears int", int_n, 1'b1);
    endtask

    task automatic t_interrupt();
        logic [7:0] b;
        pin_in = 16'h3CDA;
        wait_n(3);
        check("R9 output-mode pin silent", int_n, 1'b1);
        pin_in = 16'h3CDB;
        wait_n(3);
        check("R9 input-mode pin raises int", int_n, 1'b0);
        pin_in = 16'h3CDA;
        wait_n(3);
        check("R10 pin return clears int", int_n, 1'b1);
        pin_in = 16'h3CDB;
        wait_n(3);
        check("R9 raise again", int_n, 1'b0);
        set_ptr(8'd0);
        send_addr(1'b1);
        read_byte(b); check("R7 in0 after change", b, 8'h24);
        send_stop();
        wait_n(2);
        check("R10 port read clears int", int_n, 1'b1);
    endtask

    task automatic t_ignored();
        wait_n(1);
        send_byte(8'h77);
        wait_n(1);
        check("R11 byte outside transaction", pin_out, 16'h2211);
        send_addr(1'b0);
        send_byte(8'd2);
        rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        wait_n(1);
        check("R11 rd_req in write keeps rd_byte", rd_byte, 8'h24);
        send_byte(8'h99);
        send_stop();
        check("R11 rd_req in write keeps pointer", pin_out, 16'h2299);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_write_pairs();
        t_read_pairs();
        t_bad_cmd();
        t_input_discard();
        t_polarity();
        t_interrupt();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule